// File: doc/BRIEF.md
# Multi-Mode Three-Axis Sample FIFO

This block buffers three-axis motion samples between a sensor front end that produces one X/Y/Z triple per sample strobe and a reader that drains them at its own pace. Each entry holds one triple of 10-bit values, and the buffer holds 32 entries. The reader always sees the oldest stored triple on the head outputs and removes it with a one-cycle pop strobe. Fill level, full, empty, watermark and overrun indications are brought out as flags.

A two-bit mode input selects the fill policy. Bypass keeps the buffer empty and only tracks the newest sample. FIFO mode stops accepting samples once full. Stream mode overwrites the oldest entry once full. Stop-on-trigger mode behaves like stream mode until a trigger pulse arrives and like FIFO mode from then on. A programmable watermark can flag that enough samples have gathered for a burst read, so a host can sleep until then and drain the entries oldest first in one pass.

Top module: `axis_sample_buffer`

## Requirements
- R1: After reset the fill level is 0, empty is 1, full is 0, the overrun flag is 0 and the head triple is all zeros. Full is 1 exactly when the level is 32 and empty exactly when it is 0. The level never exceeds 32.
- R2: With mode 0 (bypass) the buffer stays empty with level 0, every sample strobe places its triple on the head outputs, and a pop has no effect.
- R3: Any cycle with mode 0 flushes the buffer: on the next cycle the level is 0, the overrun flag is 0 and the trigger latch is cleared.
- R4: With mode 1 (FIFO) a sample arriving while the buffer is full and no pop is accepted is dropped: level stays 32 and the stored contents and head are unchanged.
- R5: With mode 2 (stream) a sample arriving while the buffer is full and no pop is accepted replaces the oldest entry, so the head moves to the next oldest entry and level stays 32.
- R6: The overrun flag rises on the cycle after a sample overwrites the oldest entry, stays set, and clears on the cycle after an accepted pop.
- R7: With mode 3 (stop-on-trigger) the buffer follows stream behaviour until a cycle with the trigger input high; from the next cycle on it follows FIFO behaviour. The latched trigger is dropped whenever the mode is not 3.
- R8: The watermark flag is 1 exactly when the watermark enable is 1 and the fill level is greater than or equal to the programmed watermark level.
- R9: Entries leave in arrival order: the head outputs show the oldest stored triple whenever the buffer is not empty, with x on head_x, y on head_y and z on head_z.
- R10: In a non-bypass mode, a sample and an accepted pop in the same cycle leave the level unchanged, including when the buffer is full, in every mode.
- R11: A pop on an empty buffer is ignored: the level stays 0 and the head outputs keep the triple most recently popped (or the newest bypass sample if that came later).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | One-cycle strobe: a new triple is present |
| smp_x | input | 10 | X value of the new triple |
| smp_y | input | 10 | Y value of the new triple |
| smp_z | input | 10 | Z value of the new triple |
| mode | input | 2 | Fill policy: 0 bypass, 1 FIFO, 2 stream, 3 stop-on-trigger |
| wm_en | input | 1 | Watermark enable |
| wm_level | input | 6 | Watermark threshold in entries |
| trig | input | 1 | Trigger event for stop-on-trigger mode |
| pop | input | 1 | Remove the head entry |
| head_x | output | 10 | X value of the oldest entry |
| head_y | output | 10 | Y value of the oldest entry |
| head_z | output | 10 | Z value of the oldest entry |
| wm_flag | output | 1 | Level has reached the watermark |
| full_flag | output | 1 | All 32 entries occupied |
| empty_flag | output | 1 | No entries occupied |
| fill_level | output | 6 | Number of stored entries, 0 to 32 |
| overrun | output | 1 | A stored sample has been overwritten since the last pop |

## Verification
The assertions take the mode, sample strobe and pop as free per-cycle inputs, but assume they are stable around the clock edge and that a mode value of 0 is meant as a flush, so the overwrite and hold properties only look at cycles where the mode is non-zero and the property's preconditions (full, pop absent) hold. The stimulus changes every input only at the falling clock edge, so each rising edge sees one clean combination. Directed passes drive each mode through fill, overflow, drain and empty-pop corners, and a long random pass mixes modes, triggers, pops, watermark settings and occasional flushes so the full and overwrite preconditions recur often.

// File: rtl/asb_pkg.sv
// Package: shared constants and types for the three-axis sample buffer.
// Assumes the mode encoding below is fixed by the block's interface.
package asb_pkg;

    localparam int AXIS_W = 10;
    localparam int NUM_AXES = 3;
    localparam int WORD_W = AXIS_W * NUM_AXES;

    typedef enum logic [1:0] {
        MODE_BYPASS     = 2'd0,
        MODE_FIFO       = 2'd1,
        MODE_STREAM     = 2'd2,
        MODE_STOP_ON_TRIG = 2'd3
    } fill_mode_e;

endpackage

// File: rtl/asb_store.sv
// Module: asb_store
// Entry storage: one write port, one asynchronous read port.
// Assumes the controller never addresses a slot at or above DEPTH.
// Contents are not reset; the read side only shows written slots.
module asb_store #(
    parameter int DEPTH  = 32,
    parameter int WORD_W = 30,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] slots [DEPTH];

    // Write the selected slot on a write enable.
    always_ff @(posedge clk) begin
        if (we) begin
            slots[waddr] <= wdata;
        end
    end

    // Present the slot addressed by the read pointer.
    always_comb begin
        rdata = slots[raddr];
    end

endmodule

// File: rtl/asb_ctrl.sv
// Module: asb_ctrl
// Pointer, level, overrun and trigger-latch management for all four
// fill policies. Assumes push and pop are single-cycle strobes and that
// the mode input is stable around the rising clock edge.
module asb_ctrl
    import asb_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [1:0]       mode,
    input  logic             trig,
    output logic             we,
    output logic [PTR_W-1:0] waddr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [LVL_W-1:0] level,
    output logic             pop_ok,
    output logic             bypass,
    output logic             overrun
);

    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    fill_mode_e       mode_e;
    logic [PTR_W-1:0] wr_ptr;
    logic             trig_q;
    logic             stop_on_full;
    logic             is_full;
    logic             wr_ok;
    logic             discard;

    // Advance a pointer with wrap at the last slot.
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    // Decode the fill policy and the per-cycle accept, drop and overwrite decisions.
    always_comb begin
        mode_e       = fill_mode_e'(mode);
        bypass       = (mode_e == MODE_BYPASS);
        stop_on_full = (mode_e == MODE_FIFO) ||
                       ((mode_e == MODE_STOP_ON_TRIG) && trig_q);
        is_full      = (level == LVL_FULL);
        pop_ok       = !bypass && pop && (level != '0);
        wr_ok        = !bypass && push && (!is_full || pop_ok);
        discard      = !bypass && push && is_full && !pop_ok && !stop_on_full;
        we           = (bypass && push) || wr_ok || discard;
        waddr        = bypass ? '0 : wr_ptr;
    end

    // Update pointers, level, overrun flag and trigger latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            overrun <= 1'b0;
            trig_q  <= 1'b0;
        end else if (bypass) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            overrun <= 1'b0;
            trig_q  <= 1'b0;
        end else begin
            if (wr_ok || discard) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (pop_ok || discard) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            case ({wr_ok, pop_ok})
                2'b10:   level <= level + LVL_ONE;
                2'b01:   level <= level - LVL_ONE;
                default: level <= level;
            endcase
            if (discard) begin
                overrun <= 1'b1;
            end else if (pop_ok) begin
                overrun <= 1'b0;
            end
            trig_q <= (mode_e == MODE_STOP_ON_TRIG) && (trig_q || trig);
        end
    end

endmodule

// File: rtl/asb_head.sv
// Module: asb_head
// Head selection: the oldest stored entry when not empty, otherwise the
// triple last popped or the newest bypass sample. Assumes pop_ok is only
// asserted while the storage read port shows a valid entry.
module asb_head #(
    parameter int WORD_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              push,
    input  logic [WORD_W-1:0] sample,
    input  logic              pop_ok,
    input  logic              empty,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] head
);

    logic [WORD_W-1:0] last_q;

    // Remember the newest bypass sample or the entry being popped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (bypass && push) begin
            last_q <= sample;
        end else if (pop_ok) begin
            last_q <= rdata;
        end
    end

    // Show the oldest entry, or the remembered triple when empty.
    always_comb begin
        head = empty ? last_q : rdata;
    end

endmodule

// File: rtl/asb_flags.sv
// Module: asb_flags
// Level-derived flags: full, empty and watermark. Assumes level never
// exceeds DEPTH.
module asb_flags #(
    parameter int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] level,
    input  logic             wm_en,
    input  logic [LVL_W-1:0] wm_level,
    output logic             full,
    output logic             empty,
    output logic             wm
);

    // Compare the level against its limits and the watermark.
    always_comb begin
        full  = (level == LVL_W'(DEPTH));
        empty = (level == '0);
        wm    = wm_en && (level >= wm_level);
    end

endmodule

// File: rtl/axis_sample_buffer.sv
// Module: axis_sample_buffer
// Buffer for X/Y/Z sample triples with four fill policies (bypass, stop on
// full, overwrite oldest, overwrite until trigger then stop), head output of
// the oldest entry and level, full, empty, watermark and overrun flags.
// Assumes all inputs are synchronous to clk.
module axis_sample_buffer
    import asb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = AXIS_W,
    localparam int WW    = 3 * DW,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [DW-1:0]    smp_x,
    input  logic [DW-1:0]    smp_y,
    input  logic [DW-1:0]    smp_z,
    input  logic [1:0]       mode,
    input  logic             wm_en,
    input  logic [LVL_W-1:0] wm_level,
    input  logic             trig,
    input  logic             pop,
    output logic [DW-1:0]    head_x,
    output logic [DW-1:0]    head_y,
    output logic [DW-1:0]    head_z,
    output logic             wm_flag,
    output logic             full_flag,
    output logic             empty_flag,
    output logic [LVL_W-1:0] fill_level,
    output logic             overrun
);

    logic [WW-1:0]    sample_w;
    logic [WW-1:0]    rdata_w;
    logic [WW-1:0]    head_w;
    logic             we_w;
    logic [PTR_W-1:0] waddr_w;
    logic [PTR_W-1:0] rd_ptr_w;
    logic             pop_ok_w;
    logic             bypass_w;

    // Pack the incoming triple as {z, y, x}.
    always_comb begin
        sample_w = {smp_z, smp_y, smp_x};
    end

    asb_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (smp_valid),
        .pop     (pop),
        .mode    (mode),
        .trig    (trig),
        .we      (we_w),
        .waddr   (waddr_w),
        .rd_ptr  (rd_ptr_w),
        .level   (fill_level),
        .pop_ok  (pop_ok_w),
        .bypass  (bypass_w),
        .overrun (overrun)
    );

    asb_store #(.DEPTH(DEPTH), .WORD_W(WW)) store_i (
        .clk   (clk),
        .we    (we_w),
        .waddr (waddr_w),
        .wdata (sample_w),
        .raddr (rd_ptr_w),
        .rdata (rdata_w)
    );

    asb_flags #(.DEPTH(DEPTH)) flags_i (
        .level    (fill_level),
        .wm_en    (wm_en),
        .wm_level (wm_level),
        .full     (full_flag),
        .empty    (empty_flag),
        .wm       (wm_flag)
    );

    asb_head #(.WORD_W(WW)) head_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .bypass (bypass_w),
        .push   (smp_valid),
        .sample (sample_w),
        .pop_ok (pop_ok_w),
        .empty  (empty_flag),
        .rdata  (rdata_w),
        .head   (head_w)
    );

    // Unpack the head triple onto the per-axis outputs.
    always_comb begin
        head_x = head_w[DW-1:0];
        head_y = head_w[2*DW-1:DW];
        head_z = head_w[3*DW-1:2*DW];
    end

endmodule

// File: rtl/asb_checker.sv
// Module: asb_checker
// Temporal properties of the sample buffer, observed at its ports only.
// Assumes inputs are stable around each rising clock edge.
module asb_checker #(
    parameter int DEPTH = 32,
    parameter int DW    = 10,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [1:0]       mode,
    input logic             pop,
    input logic [DW-1:0]    head_x,
    input logic [DW-1:0]    head_y,
    input logic [DW-1:0]    head_z,
    input logic             full_flag,
    input logic             empty_flag,
    input logic [LVL_W-1:0] fill_level,
    input logic             overrun
);

    // R1: full and empty never together
    assert_full_empty_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_flag && empty_flag));

    // R1: level moves by at most one entry per non-bypass cycle
    assert_level_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0) |=> ((fill_level == $past(fill_level)) ||
                            (fill_level == $past(fill_level) + LVL_W'(1)) ||
                            (fill_level == $past(fill_level) - LVL_W'(1))));

    // R2, R3: a bypass cycle leaves the buffer empty
    assert_bypass_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> (empty_flag && !overrun));

    // R4: FIFO mode holds contents when full
    assert_fifo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd1) && full_flag && smp_valid && !pop) |=>
            (full_flag && $stable(head_x) && $stable(head_y) && $stable(head_z)));

    // R6: stream overwrite sets overrun and stays full
    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd2) && full_flag && smp_valid && !pop) |=> (overrun && full_flag));

    // R6: an accepted pop clears overrun
    assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != 2'd0) && pop && !empty_flag) |=> !overrun);

    // R10: simultaneous sample and accepted pop keep the level
    assert_pushpop_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != 2'd0) && smp_valid && pop && !empty_flag) |=> $stable(fill_level));

    // R11: pop on empty is ignored
    assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != 2'd0) && pop && empty_flag && !smp_valid) |=>
            (empty_flag && $stable(head_x) && $stable(head_y) && $stable(head_z)));

endmodule

bind axis_sample_buffer asb_checker #(.DEPTH(DEPTH), .DW(DW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .mode       (mode),
    .pop        (pop),
    .head_x     (head_x),
    .head_y     (head_y),
    .head_z     (head_z),
    .full_flag  (full_flag),
    .empty_flag (empty_flag),
    .fill_level (fill_level),
    .overrun    (overrun)
);

// File: tb/axis_sample_buffer_tb_top.sv
// Bench for axis_sample_buffer: directed corner passes per mode, then a
// seeded random pass, all compared against a queue-based reference model.
module axis_sample_buffer_tb_top;

    localparam int DEPTH = 32;
    localparam int DW    = 10;
    localparam int LVL_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_valid = 1'b0;
    logic [DW-1:0]    smp_x = '0;
    logic [DW-1:0]    smp_y = '0;
    logic [DW-1:0]    smp_z = '0;
    logic [1:0]       mode = 2'd0;
    logic             wm_en = 1'b0;
    logic [LVL_W-1:0] wm_level = '0;
    logic             trig = 1'b0;
    logic             pop = 1'b0;
    logic [DW-1:0]    head_x, head_y, head_z;
    logic             wm_flag, full_flag, empty_flag, overrun;
    logic [LVL_W-1:0] fill_level;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Reference model state
    logic [29:0] mq[$];
    logic [29:0] m_last = '0;
    bit          m_trig = 1'b0;
    bit          m_ovr = 1'b0;

    always #5 clk = ~clk;

    axis_sample_buffer #(.DEPTH(DEPTH), .DW(DW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_x      (smp_x),
        .smp_y      (smp_y),
        .smp_z      (smp_z),
        .mode       (mode),
        .wm_en      (wm_en),
        .wm_level   (wm_level),
        .trig       (trig),
        .pop        (pop),
        .head_x     (head_x),
        .head_y     (head_y),
        .head_z     (head_z),
        .wm_flag    (wm_flag),
        .full_flag  (full_flag),
        .empty_flag (empty_flag),
        .fill_level (fill_level),
        .overrun    (overrun)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model state.
    task automatic compare_all(input string tag);
        logic [29:0] eh;
        int n;
        n  = mq.size();
        eh = (n > 0) ? mq[0] : m_last;
        chk(tag, "level", 32'(fill_level), 32'(n));
        chk(tag, "full", 32'(full_flag), 32'(n == DEPTH));
        chk(tag, "empty", 32'(empty_flag), 32'(n == 0));
        chk(tag, "watermark", 32'(wm_flag), 32'(wm_en && (n >= int'(wm_level))));
        chk(tag, "overrun", 32'(overrun), 32'(m_ovr));
        chk(tag, "head", 32'({head_z, head_y, head_x}), 32'(eh));
    endtask

    // Advance the model by one clock edge with the given inputs.
    task automatic model_step(input bit v, input logic [29:0] d, input logic [1:0] md,
                              input bit t, input bit p);
        bit full, dp, stop;
        if (md == 2'd0) begin
            mq.delete();
            m_ovr  = 1'b0;
            m_trig = 1'b0;
            if (v) m_last = d;
        end else begin
            stop = (md == 2'd1) || ((md == 2'd3) && m_trig);
            full = (mq.size() == DEPTH);
            dp   = p && (mq.size() > 0);
            if (dp) begin
                m_last = mq.pop_front();
                m_ovr  = 1'b0;
            end
            if (v) begin
                if (!full || dp) begin
                    mq.push_back(d);
                end else if (!stop) begin
                    void'(mq.pop_front());
                    mq.push_back(d);
                    m_ovr = 1'b1;
                end
            end
            m_trig = (md == 2'd3) && (m_trig || t);
        end
    endtask

    // Drive one cycle of stimulus at the falling edge, then compare.
    task automatic step(input string tag, input bit v, input logic [29:0] d,
                        input logic [1:0] md, input bit t, input bit p);
        smp_valid = v;
        {smp_z, smp_y, smp_x} = d;
        mode = md;
        trig = t;
        pop  = p;
        @(posedge clk);
        model_step(v, d, md, t, p);
        @(negedge clk);
        compare_all(tag);
    endtask

    function automatic logic [29:0] rnd_word();
        return 30'($urandom);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A5F));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        compare_all("R1");

        // R2: bypass tracks the newest sample, pop has no effect
        step("R2", 1, 30'h0ABCD123, 2'd0, 0, 0);
        step("R2", 0, 30'h0, 2'd0, 0, 1);
        step("R2", 1, 30'h15555555, 2'd0, 0, 1);

        // R4: FIFO fills to 32 and drops the rest
        for (int i = 0; i < 40; i++) step("R4", 1, 30'(i * 7919 + 3), 2'd1, 0, 0);
        // R9: oldest first
        for (int i = 0; i < 3; i++) step("R9", 0, 30'h0, 2'd1, 0, 1);
        // R10: push and pop together keep level
        for (int i = 0; i < 4; i++) step("R10", 1, rnd_word(), 2'd1, 0, 1);
        for (int i = 0; i < 5; i++) step("R4", 1, rnd_word(), 2'd1, 0, 0);
        step("R10", 1, rnd_word(), 2'd1, 0, 1);
        step("R10", 1, rnd_word(), 2'd2, 0, 1);

        // R3: flush on bypass
        step("R3", 0, 30'h0, 2'd0, 0, 0);

        // R5: stream overwrites oldest
        for (int i = 0; i < 40; i++) step("R5", 1, rnd_word(), 2'd2, 0, 0);
        // R6: overrun held, then cleared by a pop
        step("R6", 0, 30'h0, 2'd2, 0, 0);
        step("R6", 0, 30'h0, 2'd2, 0, 1);
        step("R6", 1, rnd_word(), 2'd2, 0, 0);
        step("R6", 1, rnd_word(), 2'd2, 0, 0);

        // R11: drain past empty
        for (int i = 0; i < 36; i++) step("R11", 0, 30'h0, 2'd2, 0, 1);

        // R7: stop-on-trigger
        for (int i = 0; i < 36; i++) step("R7", 1, rnd_word(), 2'd3, 0, 0);
        step("R7", 1, rnd_word(), 2'd3, 1, 0);
        for (int i = 0; i < 5; i++) step("R7", 1, rnd_word(), 2'd3, 0, 0);
        step("R7", 0, 30'h0, 2'd3, 0, 1);
        step("R7", 1, rnd_word(), 2'd3, 0, 0);
        step("R7", 1, rnd_word(), 2'd2, 0, 1);
        for (int i = 0; i < 3; i++) step("R7", 1, rnd_word(), 2'd3, 0, 0);

        // R8: watermark
        step("R3", 0, 30'h0, 2'd0, 0, 0);
        wm_en = 1'b1;
        wm_level = 6'd10;
        for (int i = 0; i < 12; i++) step("R8", 1, rnd_word(), 2'd1, 0, 0);
        for (int i = 0; i < 4; i++) step("R8", 0, 30'h0, 2'd1, 0, 1);
        wm_en = 1'b0;
        step("R8", 0, 30'h0, 2'd1, 0, 0);

        // R9: random mix of all policies
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] md;
            int r;
            r  = int'($urandom % 100);
            md = (r < 4) ? 2'd0 : 2'(1 + ($urandom % 3));
            if ((i % 200) == 0) begin
                wm_en    = 1'($urandom);
                wm_level = 6'($urandom % 34);
            end
            step("R9", 1'(($urandom % 100) < 60), rnd_word(), md,
                 1'(($urandom % 100) < 3), 1'(($urandom % 100) < 45));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule